// File: doc/BRIEF.md
# Single-Bit Routing Demultiplexer with Hold Stages

This block steers one boolean input onto exactly one line of an output vector of up to 16 lines, chosen by a binary select. Every line that is not selected is driven false, so with a false input the whole vector is false and the block also serves as a one-hot decoder when the input is tied true.

Two optional clocked stages sit around the decoder. The select-hold stage keeps a copy of the select value; in level mode the live select is used while its enable is high and the last value seen with the enable high is kept while it is low, and in edge mode the kept copy is reloaded only on a rising transition of the enable and is always the one used. The vector-hold stage either passes the decoded vector through while its enable is high or freezes the whole vector while its enable is low. Either stage may be switched off by parameter. The input and every output line can be inverted individually by parameter; output inversion is applied last, after any hold.

Top module: `bit_route_demux`

## Requirements
- R1: With no inversion, the output line whose index equals the effective select carries `din`; all other lines are 0.
- R2: An effective select value greater than or equal to `N_OUTS` drives every line to 0 (before output inversion).
- R3: In level select mode with `addr_hold_en` high, the live `addr` is used in the same cycle.
- R4: In level select mode, while `addr_hold_en` is low, the select used is the `addr` present at the last clock edge at which `addr_hold_en` was high; later `addr` changes are ignored.
- R5: In edge select mode, the kept select loads `addr` only at a clock edge where `addr_hold_en` is 1 and was 0 at the previous edge; the kept value is used from the following cycle and `addr` is ignored otherwise.
- R6: With the vector-hold stage on, `out_hold_en` high makes the outputs follow the decoder in the same cycle; while it is low, the vector present at the last edge with it high is held and `din`/`addr` changes are ignored.
- R7: With a stage switched off, its enable has no effect: bypass select mode always uses live `addr`, and a disabled vector-hold stage always passes the decoder output.
- R8: With `IN_INV` set, the decoder routes the complement of `din`.
- R9: Each output line whose bit in `OUT_INV` is 1 is inverted after decode and hold.
- R10: Synchronous reset clears the kept select to 0, the held vector to all 0, and the edge-detector history to "enable was low".

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both hold stages |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Boolean value to be routed |
| addr | input | ADDR_W | Binary select of the output line |
| addr_hold_en | input | 1 | Select-hold enable (level or edge by parameter) |
| out_hold_en | input | 1 | Vector-hold enable, level sensitive |
| dout | output | N_OUTS | Routed output vector |

## Verification
The hardest situation to reach is a frozen result that no longer matches the live inputs: a kept select or held vector only shows at the ports after a specific enable history, and a wrong capture looks correct whenever the inputs happen not to move. The stimulus therefore walks a vector table where the select and input change on exactly the cycles the enables are low, so a stage that tracks the live value instead of the kept one gives a different line. Reset is applied in the middle of a run with non-zero kept state, and the edge-mode instance is given a high enable whose address changes without a new rising transition.

// File: rtl/brd_pkg.sv
package brd_pkg;

  localparam int unsigned MAX_LINES = 16;

  typedef enum logic [1:0] {
    SEL_BYPASS = 2'd0,
    SEL_LEVEL  = 2'd1,
    SEL_EDGE   = 2'd2
  } sel_mode_e;

  // One-hot placement of a bit value; an index outside the line count gives zero.
  function automatic logic [MAX_LINES-1:0] place_bit(input logic        val,
                                                     input int unsigned idx,
                                                     input int unsigned count);
    logic [MAX_LINES-1:0] res;
    res = '0;
    if (idx < count && idx < MAX_LINES) res[idx[3:0]] = val;
    return res;
  endfunction

endpackage

// File: rtl/brd_addr_hold.sv
module brd_addr_hold
  import brd_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter sel_mode_e   MODE   = SEL_LEVEL
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              en_i,
  output logic [ADDR_W-1:0] addr_o
);

  logic [ADDR_W-1:0] kept_q;
  logic              en_prev_q;
  logic              en_rise;
  logic              load;

  // Edge event against the system clock, exposed for the checks below.
  assign en_rise = en_i & ~en_prev_q;
  assign load    = (MODE == SEL_EDGE) ? en_rise : en_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      kept_q    <= '0;
      en_prev_q <= 1'b0;
    end else begin
      en_prev_q <= en_i;
      if (load) kept_q <= addr_i;
    end
  end

  generate
    if (MODE == SEL_BYPASS) begin : g_bypass
      assign addr_o = addr_i;
    end else if (MODE == SEL_LEVEL) begin : g_level
      assign addr_o = en_i ? addr_i : kept_q;

      // R4: on the enable falling, the used select is the one sampled at the last high edge
      p_level_capture_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(en_i) |-> addr_o == $past(addr_i));
      // R4: while the enable stays low the used select does not move
      p_level_keep_r4: assert property (@(posedge clk) disable iff (rst)
        (!en_i && $past(!en_i)) |-> $stable(addr_o));
    end else begin : g_edge
      assign addr_o = kept_q;

      // R5: a rising enable loads the select seen at that edge
      p_edge_load_r5: assert property (@(posedge clk) disable iff (rst)
        en_rise |=> addr_o == $past(addr_i));
      // R5: no rising enable, no change of the used select
      p_edge_keep_r5: assert property (@(posedge clk) disable iff (rst)
        !en_rise |=> $stable(addr_o));
    end
  endgenerate

endmodule

// File: rtl/brd_decode.sv
module brd_decode
  import brd_pkg::*;
#(
  parameter int unsigned N_OUTS = 16,
  parameter int unsigned ADDR_W = 4,
  parameter bit          IN_INV = 1'b0
) (
  input  logic              din_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [N_OUTS-1:0] vec_o,
  output logic              routed_o
);

  logic [MAX_LINES-1:0] full_vec;

  assign routed_o = din_i ^ IN_INV;
  assign full_vec = place_bit(routed_o, 32'(addr_i), N_OUTS);
  assign vec_o    = full_vec[N_OUTS-1:0];

endmodule

// File: rtl/brd_out_hold.sv
module brd_out_hold #(
  parameter int unsigned N_OUTS  = 16,
  parameter bit          HOLD_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_OUTS-1:0] vec_i,
  input  logic              en_i,
  output logic [N_OUTS-1:0] vec_o
);

  generate
    if (HOLD_EN) begin : g_hold
      logic [N_OUTS-1:0] frozen_q;

      always_ff @(posedge clk) begin
        if (rst)       frozen_q <= '0;
        else if (en_i) frozen_q <= vec_i;
      end

      assign vec_o = en_i ? vec_i : frozen_q;

      // R6: when the enable drops, the vector from the last high edge is shown
      p_vec_capture_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(en_i) |-> vec_o == $past(vec_i));
      // R6: while the enable stays low the outputs are frozen
      p_vec_keep_r6: assert property (@(posedge clk) disable iff (rst)
        (!en_i && $past(!en_i)) |-> $stable(vec_o));
    end else begin : g_pass
      assign vec_o = vec_i;
    end
  endgenerate

endmodule

// File: rtl/bit_route_demux.sv
module bit_route_demux
  import brd_pkg::*;
#(
  parameter int unsigned         N_OUTS      = 16,
  parameter int unsigned         ADDR_W      = 4,
  parameter sel_mode_e           SEL_MODE    = SEL_LEVEL,
  parameter bit                  OUT_HOLD_EN = 1'b1,
  parameter bit                  IN_INV      = 1'b0,
  parameter logic [N_OUTS-1:0]   OUT_INV     = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              din,
  input  logic [ADDR_W-1:0] addr,
  input  logic              addr_hold_en,
  input  logic              out_hold_en,
  output logic [N_OUTS-1:0] dout
);

  localparam int unsigned SEL_SPAN = 1 << ADDR_W;

  logic [ADDR_W-1:0] eff_addr;
  logic [N_OUTS-1:0] dec_vec;
  logic [N_OUTS-1:0] held_vec;
  logic              routed;
  logic              sel_in_range;

  brd_addr_hold #(.ADDR_W(ADDR_W), .MODE(SEL_MODE)) u_sel (
    .clk    (clk),
    .rst    (rst),
    .addr_i (addr),
    .en_i   (addr_hold_en),
    .addr_o (eff_addr)
  );

  brd_decode #(.N_OUTS(N_OUTS), .ADDR_W(ADDR_W), .IN_INV(IN_INV)) u_dec (
    .din_i    (din),
    .addr_i   (eff_addr),
    .vec_o    (dec_vec),
    .routed_o (routed)
  );

  brd_out_hold #(.N_OUTS(N_OUTS), .HOLD_EN(OUT_HOLD_EN)) u_hold (
    .clk   (clk),
    .rst   (rst),
    .vec_i (dec_vec),
    .en_i  (out_hold_en),
    .vec_o (held_vec)
  );

  assign dout = held_vec ^ OUT_INV;

  assign sel_in_range = (32'(eff_addr) < N_OUTS) && (32'(eff_addr) < SEL_SPAN);

  // R1: the decoder never raises more than one line
  p_one_line_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dec_vec));
  // R1: a routed true on an in-range select raises exactly one line
  p_line_raised_r1: assert property (@(posedge clk) disable iff (rst)
    (routed && sel_in_range) |-> $countones(dec_vec) == 1);
  // R2: an out-of-range select raises nothing
  p_out_of_range_r2: assert property (@(posedge clk) disable iff (rst)
    !sel_in_range |-> dec_vec == '0);

endmodule

// File: tb/bit_route_demux_test.sv
module bit_route_demux_test;
  import brd_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Main instance: 12 lines, level select hold, vector hold on, no inversion.
  logic        din = 0, aen = 0, oen = 0;
  logic [3:0]  addr = 0;
  logic [11:0] dout;

  bit_route_demux #(.N_OUTS(12), .ADDR_W(4), .SEL_MODE(SEL_LEVEL), .OUT_HOLD_EN(1'b1),
                    .IN_INV(1'b0), .OUT_INV(12'h000)) uut (
    .clk(clk), .rst(rst), .din(din), .addr(addr),
    .addr_hold_en(aen), .out_hold_en(oen), .dout(dout));

  // Edge select mode, vector hold off, inverted input, lines 0 and 7 inverted.
  logic       e_din = 0, e_aen = 0, e_oen = 0;
  logic [2:0] e_addr = 0;
  logic [7:0] e_dout;

  bit_route_demux #(.N_OUTS(8), .ADDR_W(3), .SEL_MODE(SEL_EDGE), .OUT_HOLD_EN(1'b0),
                    .IN_INV(1'b1), .OUT_INV(8'h81)) uut_edge (
    .clk(clk), .rst(rst), .din(e_din), .addr(e_addr),
    .addr_hold_en(e_aen), .out_hold_en(e_oen), .dout(e_dout));

  // Bypass select mode, 4 lines.
  logic       o_din = 0, o_aen = 0, o_oen = 0;
  logic [1:0] o_addr = 0;
  logic [3:0] o_dout;

  bit_route_demux #(.N_OUTS(4), .ADDR_W(2), .SEL_MODE(SEL_BYPASS), .OUT_HOLD_EN(1'b1),
                    .IN_INV(1'b0), .OUT_INV(4'h0)) uut_byp (
    .clk(clk), .rst(rst), .din(o_din), .addr(o_addr),
    .addr_hold_en(o_aen), .out_hold_en(o_oen), .dout(o_dout));

  // Vector fields: {din, addr[3:0], aen, oen, expected[11:0]}, one per cycle.
  localparam int NV = 16;
  localparam logic [18:0] VEC [NV] = '{
    {1'b1, 4'd3,  1'b1, 1'b1, 12'h008},  // R1
    {1'b1, 4'd11, 1'b1, 1'b1, 12'h800},  // R1 top line
    {1'b0, 4'd5,  1'b1, 1'b1, 12'h000},  // R1 false input
    {1'b1, 4'd12, 1'b1, 1'b1, 12'h000},  // R2 first out-of-range
    {1'b1, 4'd15, 1'b1, 1'b1, 12'h000},  // R2 largest select
    {1'b1, 4'd6,  1'b1, 1'b1, 12'h040},  // R3 live select
    {1'b1, 4'd2,  1'b0, 1'b1, 12'h040},  // R4 kept select 6
    {1'b1, 4'd9,  1'b0, 1'b1, 12'h040},  // R4
    {1'b0, 4'd9,  1'b0, 1'b1, 12'h000},  // R4 input still live
    {1'b1, 4'd9,  1'b1, 1'b1, 12'h200},  // R3
    {1'b1, 4'd1,  1'b1, 1'b0, 12'h200},  // R6 frozen vector
    {1'b0, 4'd4,  1'b1, 1'b0, 12'h200},  // R6
    {1'b1, 4'd7,  1'b1, 1'b1, 12'h080},  // R6 follows again
    {1'b1, 4'd0,  1'b1, 1'b0, 12'h080},  // R6
    {1'b1, 4'd0,  1'b0, 1'b1, 12'h001},  // R4 kept select 0
    {1'b1, 4'd10, 1'b1, 1'b1, 12'h400}   // R3
  };
  localparam string VREQ [NV] = '{"R1", "R1", "R1", "R2", "R2", "R3", "R4", "R4",
                                   "R4", "R3", "R6", "R6", "R6", "R6", "R4", "R3"};

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R10: after reset the held vector is zero and the kept select is zero
    din = 1; addr = 4'd5; aen = 0; oen = 0;
    e_din = 0; e_aen = 0; e_oen = 0; e_addr = 3'd4;
    #1;
    check("R10", 16'(dout), 16'h000);
    // R10 R8 R9: edge instance kept select 0, routed ~0 = 1, lines 0 and 7 inverted
    check("R10", 16'(e_dout), 16'h80);

    @(negedge clk); oen = 1; #1;
    check("R10", 16'(dout), 16'h001);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {din, addr, aen, oen} = VEC[i][18:12];
      #1;
      check(VREQ[i], 16'(dout), 16'(VEC[i][11:0]));
    end

    // R10: reset in mid-run with kept select 10 and held vector 0x400
    @(negedge clk); rst = 1; aen = 0; oen = 0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 0; #1;
    check("R10", 16'(dout), 16'h000);
    @(negedge clk); oen = 1; din = 1; addr = 4'd8; #1;
    check("R10", 16'(dout), 16'h001);
    oen = 0; aen = 0;

    // Edge instance.
    @(negedge clk); e_din = 1; #1;
    check("R8", 16'(e_dout), 16'h81);      // routed 0: only inversion shows (R9)
    @(negedge clk); e_din = 0; e_aen = 1; e_addr = 3'd5; #1;
    check("R5", 16'(e_dout), 16'h80);      // load not visible until next cycle
    @(negedge clk); e_addr = 3'd2; #1;
    check("R5", 16'(e_dout), 16'hA1);      // kept 5: 0x20 ^ 0x81
    @(negedge clk); e_aen = 0; e_addr = 3'd3; #1;
    check("R5", 16'(e_dout), 16'hA1);
    @(negedge clk); e_aen = 1; e_oen = 0; #1;
    check("R7", 16'(e_dout), 16'hA1);      // vector hold off: low enable no freeze
    @(negedge clk); e_addr = 3'd6; e_oen = 1; #1;
    check("R5", 16'(e_dout), 16'h89);      // kept 3: 0x08 ^ 0x81
    @(negedge clk); e_din = 1; #1;
    check("R9", 16'(e_dout), 16'h81);

    // Bypass select instance.
    @(negedge clk); o_din = 1; o_oen = 1; o_aen = 0; o_addr = 2'd2; #1;
    check("R7", 16'(o_dout), 16'h4);
    @(negedge clk); o_addr = 2'd1; #1;
    check("R7", 16'(o_dout), 16'h2);
    @(negedge clk); o_aen = 1; o_addr = 2'd3; #1;
    check("R1", 16'(o_dout), 16'h8);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule